// File: doc/BRIEF.md
# SCSI Initiator Status and Message Phase Sequencer

This block runs the initiator end of a parallel SCSI bus during the status, message-in and message-out phases. A controller starts a transfer by pulsing a command strobe with a command code and a byte count. The block then follows the target-driven phase lines and REQ, answers every REQ with ACK, and moves each byte between the bus and one of two internal FIFOs. Incoming bytes go to a receive FIFO that the controller drains. Outgoing bytes come from a transmit FIFO that the controller fills.

The phase lines are compared with the expected phase at the first cycle of each REQ assertion. If they do not match, the command stops without asserting ACK. After the last byte of a message-in, ACK is left asserted. Software can then signal attention before it releases the byte, and the next command start releases it. Completion, phase mismatch and rejected commands each set a sticky flag. Any set flag drives the interrupt line.

Top module: `scsi_ini_phase_exec`

## Requirements
- R1: When a command is accepted (strobe while idle, code not 00, and either connected or code 01), `bus_ack` is low from the next cycle on, even if a prior transfer left it high.
- R2: Code 01 (status) transfers exactly one byte and ignores `byte_count`. The phase lines {MSG,C/D,I/O} must read 011.
- R3: Code 10 (message-in) receives `byte_count` bytes into the receive FIFO, in bus order. At every REQ assertion it checks that the phase lines read 111.
- R4: While the receive FIFO is full, ACK is withheld from a pending REQ. It is raised once the controller pops a byte, and no byte is lost.
- R5: Code 11 (message-out) drives `byte_count` bytes from the transmit FIFO onto `bus_data_out`, with `bus_data_oe` high, and expects phase 110. While the transmit FIFO is empty, ACK is withheld.
- R6: A code 10 or 11 command issued while `connected` is low does not run. On the next cycle it sets `int_cmd_err` and `int_bus_grp`, and `busy` stays low.
- R7: Normal completion sets `int_good` in the cycle `busy` falls. `irq` is the OR of the four flags, and `int_clr` clears all of them.
- R8: If the phase lines do not match at a REQ assertion, ACK is never raised for that REQ, `int_phase_err` is set and the block returns to idle.
- R9: The received byte is the value on `bus_data_in` at the edge where ACK rises. ACK stays high for as long as REQ stays high, and for a non-final byte it drops on the edge after REQ falls.
- R10: After the final byte of a message-in, ACK stays high after REQ falls until the next accepted command. After the final byte of status or message-out, ACK is released.
- R11: A message command with `byte_count` of 0 completes at once with `int_good` and makes no handshake.
- R12: A command strobe while `busy` is high is ignored. A message-in with a count of 1 can be followed by another message-in for the remaining bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 2 | 01 status, 10 message-in, 11 message-out, 00 none |
| byte_count | input | CNT_W | Bytes to move for message commands |
| connected | input | 1 | High while a bus connection exists |
| int_clr | input | 1 | Clears all interrupt flags |
| bus_phase | input | 3 | Phase lines {MSG, C/D, I/O} |
| bus_req | input | 1 | REQ from the target, active high |
| bus_data_in | input | DATA_W | Bus data from the target |
| bus_ack | output | 1 | ACK to the target, active high |
| bus_data_out | output | DATA_W | Byte driven in message-out |
| bus_data_oe | output | 1 | Output enable for bus_data_out |
| rx_pop | input | 1 | Controller pops the receive FIFO |
| rx_rdata | output | DATA_W | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_push | input | 1 | Controller pushes into the transmit FIFO |
| tx_wdata | input | DATA_W | Byte to push |
| tx_full | output | 1 | Transmit FIFO full |
| busy | output | 1 | A command is running |
| int_good | output | 1 | Normal completion flag |
| int_phase_err | output | 1 | Phase mismatch flag |
| int_cmd_err | output | 1 | Rejected command flag |
| int_bus_grp | output | 1 | Bus-event group flag, set with a rejected command |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the receive FIFO and then raises one more REQ. A design that ignores the full flag would ACK that REQ and drop the byte. It also starts a message-out with an empty transmit FIFO; a flawed design would put stale data on the bus. It holds REQ high for several cycles after ACK and changes the data under it, which exposes a design that lets go of ACK early or samples the data late. It checks that ACK stays held after a final message-in byte and drops at the next start, which catches a design that releases it at the wrong moment or never. Finally, it presents a wrong phase at REQ, strobes a command mid-transfer, and issues message commands while disconnected or with a zero count. These catch a design that handshakes anyway, restarts, or runs when it should refuse.

// File: rtl/sip_pkg.sv
package sip_pkg;
   typedef enum logic [1:0] {
      CMD_NONE    = 2'b00,
      CMD_STATUS  = 2'b01,
      CMD_MSG_IN  = 2'b10,
      CMD_MSG_OUT = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_WAIT  = 2'd1,
      S_READY = 2'd2,
      S_ACKED = 2'd3
   } st_e;

   // phase lines ordered {MSG, C/D, I/O}
   localparam logic [2:0] PH_STATUS  = 3'b011;
   localparam logic [2:0] PH_MSG_IN  = 3'b111;
   localparam logic [2:0] PH_MSG_OUT = 3'b110;

   function automatic logic [2:0] exp_phase(cmd_e c);
      case (c)
         CMD_MSG_IN:  exp_phase = PH_MSG_IN;
         CMD_MSG_OUT: exp_phase = PH_MSG_OUT;
         default:     exp_phase = PH_STATUS;
      endcase
   endfunction
endpackage

// File: rtl/sip_fifo.sv
module sip_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("sip_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic         vld;
      logic [W-1:0] hold;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld  <= 1'b0;
            hold <= '0;
         end else if (push && !vld) begin
            vld  <= 1'b1;
            hold <= wdata;
         end else if (pop && vld) begin
            vld <= 1'b0;
         end
      end
      assign rdata = hold;
      assign full  = vld;
      assign empty = !vld;
   end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      localparam logic [AW:0]   N_FULL = DEPTH[AW:0];
      localparam logic [AW-1:0] P_LAST = AW'(DEPTH - 1);
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [AW:0]   cnt;
      logic          do_push, do_pop;

      assign full    = (cnt == N_FULL);
      assign empty   = (cnt == '0);
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;
      assign rdata   = mem[rp];

      always_ff @(posedge clk) begin
         if (do_push) mem[wp] <= wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (do_push) wp <= (wp == P_LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == P_LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt <= cnt + 1'b1;
               2'b01:   cnt <= cnt - 1'b1;
               default: cnt <= cnt;
            endcase
         end
      end
   end
endmodule

// File: rtl/sip_seq.sv
module sip_seq
   import sip_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_code,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic              connected,
   input  logic              int_clr,
   input  logic [2:0]        bus_phase,
   input  logic              bus_req,
   input  logic              rx_full,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_head,
   output logic              rx_push,
   output logic              tx_pop,
   output logic              bus_ack,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   output logic              busy,
   output logic              int_good,
   output logic              int_phase_err,
   output logic              int_cmd_err,
   output logic              int_bus_grp
);
   st_e              st;
   cmd_e             cur;
   cmd_e             req_cmd;
   logic [CNT_W-1:0] remain;
   logic             dir_out, xfer_go;

   assign req_cmd = cmd_e'(cmd_code);
   assign dir_out = (cur == CMD_MSG_OUT);
   assign xfer_go = (st == S_READY) && (dir_out ? !tx_empty : !rx_full);
   assign rx_push = xfer_go && !dir_out;
   assign tx_pop  = xfer_go && dir_out;
   assign busy    = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= S_IDLE;
         cur           <= CMD_NONE;
         remain        <= '0;
         bus_ack       <= 1'b0;
         bus_data_out  <= '0;
         bus_data_oe   <= 1'b0;
         int_good      <= 1'b0;
         int_phase_err <= 1'b0;
         int_cmd_err   <= 1'b0;
         int_bus_grp   <= 1'b0;
      end else begin
         if (int_clr) begin
            int_good      <= 1'b0;
            int_phase_err <= 1'b0;
            int_cmd_err   <= 1'b0;
            int_bus_grp   <= 1'b0;
         end
         case (st)
            S_IDLE: begin
               if (cmd_valid && req_cmd != CMD_NONE) begin
                  if (req_cmd != CMD_STATUS && !connected) begin
                     int_cmd_err <= 1'b1;
                     int_bus_grp <= 1'b1;
                  end else begin
                     bus_ack <= 1'b0;
                     cur     <= req_cmd;
                     remain  <= (req_cmd == CMD_STATUS) ? CNT_W'(1) : byte_count;
                     if (req_cmd != CMD_STATUS && byte_count == '0) begin
                        int_good <= 1'b1;
                     end else begin
                        st          <= S_WAIT;
                        bus_data_oe <= (req_cmd == CMD_MSG_OUT);
                     end
                  end
               end
            end
            S_WAIT: begin
               if (bus_req) begin
                  if (bus_phase != exp_phase(cur)) begin
                     int_phase_err <= 1'b1;
                     bus_data_oe   <= 1'b0;
                     st            <= S_IDLE;
                  end else begin
                     st <= S_READY;
                  end
               end
            end
            S_READY: begin
               if (xfer_go) begin
                  bus_ack <= 1'b1;
                  st      <= S_ACKED;
                  if (dir_out) bus_data_out <= tx_head;
               end
            end
            S_ACKED: begin
               if (!bus_req) begin
                  remain <= remain - 1'b1;
                  if (remain == CNT_W'(1)) begin
                     int_good    <= 1'b1;
                     bus_data_oe <= 1'b0;
                     st          <= S_IDLE;
                     if (cur != CMD_MSG_IN) bus_ack <= 1'b0;
                  end else begin
                     bus_ack <= 1'b0;
                     st      <= S_WAIT;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/scsi_ini_phase_exec.sv
module scsi_ini_phase_exec #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 8,
   parameter int RX_DEPTH = 4,
   parameter int TX_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_code,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic              connected,
   input  logic              int_clr,
   input  logic [2:0]        bus_phase,
   input  logic              bus_req,
   input  logic [DATA_W-1:0] bus_data_in,
   output logic              bus_ack,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_empty,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_full,
   output logic              busy,
   output logic              int_good,
   output logic              int_phase_err,
   output logic              int_cmd_err,
   output logic              int_bus_grp,
   output logic              irq
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("scsi_ini_phase_exec: CNT_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("scsi_ini_phase_exec: DATA_W must be at least 1");
   end

   logic              rx_push, rx_full;
   logic              tx_pop, tx_empty;
   logic [DATA_W-1:0] tx_head;

   sip_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(bus_data_in),
      .pop(rx_pop), .rdata(rx_rdata),
      .full(rx_full), .empty(rx_empty)
   );

   sip_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(tx_wdata),
      .pop(tx_pop), .rdata(tx_head),
      .full(tx_full), .empty(tx_empty)
   );

   sip_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .byte_count(byte_count),
      .connected(connected), .int_clr(int_clr),
      .bus_phase(bus_phase), .bus_req(bus_req),
      .rx_full(rx_full), .tx_empty(tx_empty), .tx_head(tx_head),
      .rx_push(rx_push), .tx_pop(tx_pop),
      .bus_ack(bus_ack), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
      .busy(busy),
      .int_good(int_good), .int_phase_err(int_phase_err),
      .int_cmd_err(int_cmd_err), .int_bus_grp(int_bus_grp)
   );

   assign irq = int_good | int_phase_err | int_cmd_err | int_bus_grp;
endmodule

// File: rtl/sip_checker.sv
module sip_checker
   import sip_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [1:0] cmd_code,
   input logic       connected,
   input logic       busy,
   input logic       bus_req,
   input logic       bus_ack,
   input logic       rx_push,
   input logic       rx_full,
   input logic       tx_pop,
   input logic       tx_empty,
   input logic       int_good,
   input logic       int_cmd_err,
   input logic       int_bus_grp
);
   logic accept, reject;
   assign accept = cmd_valid && !busy && cmd_code != CMD_NONE &&
                   (connected || cmd_code == CMD_STATUS);
   assign reject = cmd_valid && !busy && cmd_code[1] && !connected;

   p_start_drops_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !bus_ack);

   p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !rx_push);

   p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> !tx_pop);

   p_refuse_disc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> (int_cmd_err && int_bus_grp && !busy));

   p_good_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_good) |-> !busy);

   p_ack_held_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_ack && bus_req) |=> bus_ack);
endmodule

bind scsi_ini_phase_exec sip_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .connected(connected), .busy(busy), .bus_req(bus_req), .bus_ack(bus_ack),
   .rx_push(rx_push), .rx_full(rx_full), .tx_pop(tx_pop), .tx_empty(tx_empty),
   .int_good(int_good), .int_cmd_err(int_cmd_err), .int_bus_grp(int_bus_grp)
);

// File: tb/tb_scsi_ini_phase_exec.sv
module tb_scsi_ini_phase_exec;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_code = 2'b00;
   logic [7:0] byte_count = '0;
   logic       connected = 1'b1;
   logic       int_clr = 1'b0;
   logic [2:0] bus_phase = 3'b000;
   logic       bus_req = 1'b0;
   logic [7:0] bus_data_in = '0;
   logic       bus_ack, bus_data_oe, rx_empty, tx_full, busy, irq;
   logic [7:0] bus_data_out, rx_rdata;
   logic       rx_pop = 1'b0, tx_push = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic       int_good, int_phase_err, int_cmd_err, int_bus_grp;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   scsi_ini_phase_exec dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .byte_count(byte_count), .connected(connected), .int_clr(int_clr),
      .bus_phase(bus_phase), .bus_req(bus_req), .bus_data_in(bus_data_in),
      .bus_ack(bus_ack), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
      .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
      .busy(busy), .int_good(int_good), .int_phase_err(int_phase_err),
      .int_cmd_err(int_cmd_err), .int_bus_grp(int_bus_grp), .irq(irq)
   );

   // command codes and phase values as given in the requirements
   localparam logic [1:0] C_ST = 2'b01, C_MI = 2'b10, C_MO = 2'b11;
   localparam logic [2:0] P_ST = 3'b011, P_MI = 3'b111, P_MO = 3'b110;

   // {code, count, first byte}
   localparam logic [13:0] VEC [7] = '{
      {C_ST, 4'd7, 8'hA5},
      {C_MI, 4'd1, 8'h10},
      {C_MI, 4'd3, 8'h20},
      {C_MO, 4'd1, 8'h30},
      {C_MO, 4'd4, 8'h40},
      {C_MI, 4'd4, 8'h55},
      {C_ST, 4'd0, 8'h3C}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] code, input logic [7:0] cnt);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; byte_count = cnt;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic clear_ints();
      @(negedge clk); int_clr = 1'b1;
      @(negedge clk); int_clr = 1'b0;
   endtask

   task automatic tx_write(input logic [7:0] d);
      @(negedge clk); tx_push = 1'b1; tx_wdata = d;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic rx_read(input string tag, input logic [7:0] exp);
      @(negedge clk);
      chk(tag, {31'd0, rx_empty}, 32'd0);
      chk(tag, {24'd0, rx_rdata}, {24'd0, exp});
      rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic tgt_in(input logic [2:0] ph, input logic [7:0] d);
      @(negedge clk);
      while (bus_ack) @(negedge clk);
      bus_phase = ph; bus_data_in = d; bus_req = 1'b1;
      while (!bus_ack) @(negedge clk);
      bus_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic tgt_out(input logic [2:0] ph, output logic [7:0] d, output logic oe);
      @(negedge clk);
      while (bus_ack) @(negedge clk);
      bus_phase = ph; bus_req = 1'b1;
      while (!bus_ack) @(negedge clk);
      d = bus_data_out; oe = bus_data_oe;
      bus_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] got;
      logic       oe;
      repeat (3) @(negedge clk);
      // reset state
      chk("R7 reset irq", {31'd0, irq}, 0);
      chk("R1 reset ack", {31'd0, bus_ack}, 0);
      chk("R12 reset busy", {31'd0, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table of complete transfers (R2 R3 R5 R7 R12)
      for (int v = 0; v < 7; v++) begin
         logic [1:0] code;
         logic [3:0] cnt;
         logic [7:0] seed;
         int n;
         logic [2:0] ph;
         {code, cnt, seed} = VEC[v];
         n  = (code == C_ST) ? 1 : int'(cnt);
         ph = (code == C_ST) ? P_ST : (code == C_MI) ? P_MI : P_MO;
         if (code == C_MO)
            for (int i = 0; i < n; i++) tx_write(seed + 8'(i));
         issue(code, {4'd0, cnt});
         chk("R1 ack low after start", {31'd0, bus_ack}, 0);
         for (int i = 0; i < n; i++) begin
            if (code == C_MO) begin
               tgt_out(ph, got, oe);
               chk("R5 out byte", {24'd0, got}, {24'd0, seed + 8'(i)});
               chk("R5 oe", {31'd0, oe}, 1);
            end else begin
               tgt_in(ph, seed + 8'(i));
            end
         end
         wait_idle();
         chk("R7 good", {31'd0, int_good}, 1);
         chk("R7 irq", {31'd0, irq}, 1);
         if (code != C_MO)
            for (int i = 0; i < n; i++)
               rx_read((code == C_ST) ? "R2 status byte" : "R3 msg byte", seed + 8'(i));
         if (code == C_ST) chk("R2 single byte", {31'd0, rx_empty}, 1);
         clear_ints();
         chk("R7 clear", {31'd0, irq}, 0);
      end

      // R10 hold after final message-in byte, then R1 release at next start
      issue(C_MI, 8'd1);
      tgt_in(P_MI, 8'h77);
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R10 ack held", {31'd0, bus_ack}, 1);
      issue(C_ST, 8'd0);
      chk("R1 start releases held ack", {31'd0, bus_ack}, 0);
      tgt_in(P_ST, 8'h5A);
      wait_idle();
      chk("R10 status releases ack", {31'd0, bus_ack}, 0);
      rx_read("R10 byte", 8'h77);
      rx_read("R2 byte", 8'h5A);
      clear_ints();

      // R8 phase mismatch
      issue(C_MI, 8'd2);
      @(negedge clk);
      bus_phase = P_ST; bus_req = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 no ack", {31'd0, bus_ack}, 0);
      chk("R8 phase flag", {31'd0, int_phase_err}, 1);
      chk("R8 idle", {31'd0, busy}, 0);
      chk("R8 no good", {31'd0, int_good}, 0);
      chk("R8 rx untouched", {31'd0, rx_empty}, 1);
      bus_req = 1'b0;
      clear_ints();

      // R6 disconnected message command
      connected = 1'b0;
      issue(C_MO, 8'd1);
      chk("R6 cmd err", {31'd0, int_cmd_err}, 1);
      chk("R6 grp", {31'd0, int_bus_grp}, 1);
      chk("R6 not busy", {31'd0, busy}, 0);
      chk("R6 no oe", {31'd0, bus_data_oe}, 0);
      chk("R6 irq", {31'd0, irq}, 1);
      connected = 1'b1;
      clear_ints();
      chk("R7 clear after err", {31'd0, irq}, 0);

      // R11 zero count
      issue(C_MI, 8'd0);
      chk("R11 good", {31'd0, int_good}, 1);
      chk("R11 idle", {31'd0, busy}, 0);
      chk("R11 no ack", {31'd0, bus_ack}, 0);
      clear_ints();

      // R4 receive FIFO full holds handshake
      issue(C_MI, 8'd5);
      for (int i = 0; i < 4; i++) tgt_in(P_MI, 8'h80 + 8'(i));
      @(negedge clk);
      bus_phase = P_MI; bus_data_in = 8'h84; bus_req = 1'b1;
      repeat (5) @(negedge clk);
      chk("R4 ack withheld", {31'd0, bus_ack}, 0);
      chk("R4 still busy", {31'd0, busy}, 1);
      rx_read("R4 first", 8'h80);
      while (!bus_ack) @(negedge clk);
      bus_req = 1'b0;
      wait_idle();
      chk("R4 good", {31'd0, int_good}, 1);
      for (int i = 1; i < 5; i++) rx_read("R4 no loss", 8'h80 + 8'(i));
      clear_ints();

      // R5 transmit FIFO empty holds handshake
      issue(C_MO, 8'd1);
      @(negedge clk);
      bus_phase = P_MO; bus_req = 1'b1;
      repeat (4) @(negedge clk);
      chk("R5 ack withheld", {31'd0, bus_ack}, 0);
      tx_write(8'hE1);
      while (!bus_ack) @(negedge clk);
      chk("R5 late byte", {24'd0, bus_data_out}, 32'hE1);
      chk("R5 oe late", {31'd0, bus_data_oe}, 1);
      bus_req = 1'b0;
      wait_idle();
      chk("R10 out releases ack", {31'd0, bus_ack}, 0);
      chk("R5 oe off", {31'd0, bus_data_oe}, 0);
      clear_ints();

      // R9 ack held while REQ high, byte captured at ACK rise
      issue(C_MI, 8'd2);
      @(negedge clk);
      while (bus_ack) @(negedge clk);
      bus_phase = P_MI; bus_data_in = 8'h9C; bus_req = 1'b1;
      while (!bus_ack) @(negedge clk);
      bus_data_in = 8'h00;
      repeat (3) @(negedge clk);
      chk("R9 ack held", {31'd0, bus_ack}, 1);
      bus_req = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 ack released", {31'd0, bus_ack}, 0);
      tgt_in(P_MI, 8'h9D);
      wait_idle();
      rx_read("R9 latched byte", 8'h9C);
      rx_read("R9 second byte", 8'h9D);
      clear_ints();

      // R12 strobe while busy ignored
      issue(C_MI, 8'd2);
      tgt_in(P_MI, 8'hC1);
      issue(C_ST, 8'd1);
      tgt_in(P_MI, 8'hC2);
      wait_idle();
      chk("R12 no phase err", {31'd0, int_phase_err}, 0);
      chk("R12 good", {31'd0, int_good}, 1);
      rx_read("R12 byte", 8'hC1);
      rx_read("R12 byte", 8'hC2);
      clear_ints();

      finish_run();
   end
endmodule